// File: doc/BRIEF.md
# Multiplexed Asynchronous Bus FIFO Slave

This block is the peripheral end of a 16-bit asynchronous host bus that carries the address and the data on the same lines. The host asserts chip select, drives a byte address on the shared lines while the address-valid strobe is low, and then runs either a write strobe or an output-enable strobe. Every pin is brought into a fast internal clock through a two-flop synchroniser. The address lines and the strobes go through the same delay, so the captured address and data line up with the strobes that framed them.

Three word addresses are decoded. A fixed identification word can be read back during bring-up. One address accepts writes into a 16-entry FIFO, and a read of that same address returns the FIFO occupancy. A second address returns the FIFO entries in the order they were written, and each bus read consumes one entry. The shared lines are driven only while chip select and output enable are both low, so the host can use them freely at all other times.

The sequencer has five states. ST_IDLE waits for chip select together with address valid. ST_ADDR latches the address while the address strobe stays low. ST_READ holds during the output-enable strobe, and ST_WRITE holds during the write strobe. ST_END waits for chip select to go away, or for a new address phase with chip select still held low. The transitions are:
- IDLE→ADDR: chip select and address valid both low.
- ADDR→READ: the address strobe has ended and output enable is low.
- ADDR→WRITE: the address strobe has ended and write enable is low.
- ADDR/READ/WRITE→IDLE: chip select is released.
- READ→END: output enable rises. This pops the FIFO when the pop address was selected.
- WRITE→END: write enable rises. This pushes the FIFO when the push address was selected.
- END→ADDR: a new address strobe arrives.
- END→IDLE: chip select is released.

Top module: `adbus_fifo_slave`

## Requirements
- R1: After reset the FIFO is empty, a read of byte address 0x4000 returns 0x0000, and no strobe is active.
- R2: The address is taken from the shared lines while address valid (active low) is asserted. Bit 0 is ignored, so 0x2469 reads the same as 0x2468, and a write to 0x4001 pushes like a write to 0x4000. Each strobe phase must last at least three internal clock periods.
- R3: A read of byte address 0x2468 returns 0x55AA. A read of any address that is not decoded returns 0x0000.
- R4: Each write to byte address 0x4000 pushes the data word into the FIFO. A write to any other undecoded address changes nothing.
- R5: Each read of byte address 0x4002 returns the oldest FIFO entry, so words come back in the order they were written.
- R6: A read of byte address 0x4000 returns the FIFO occupancy in bits 4..0, with the upper bits zero, and removes nothing.
- R7: A read of 0x4002 from an empty FIFO returns 0x0000 and leaves the occupancy at zero.
- R8: The FIFO holds 16 words. A write into a full FIFO is dropped, and the 16 stored words keep their order.
- R9: The block drives the shared lines only while chip select and output enable are both low. At all other times it leaves them at high impedance.
- R10: Exactly one entry is removed per read of 0x4002, at the end of output enable. The returned word stays stable for the whole output-enable window.
- R11: If chip select is released before the write strobe ends, the write is abandoned and nothing is pushed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_av_n | input | 1 | Address valid strobe, active low |
| bus_oe_n | input | 1 | Output enable (read strobe), active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_ad | inout | 16 | Shared address/data lines |

## Verification
The hardest state to reach is a full FIFO that is then offered one more write. Reaching it takes sixteen complete write cycles, each with its own address phase, followed by a seventeenth write. The stimulus then reads the occupancy and drains all sixteen words, which shows that the dropped word was never stored. An abandoned write needs chip select to fall back while the write strobe is still low. The stimulus builds this by raising chip select several clocks before write enable, so that the synchronised chip select arrives first.

// File: rtl/adbus_pkg.sv
package adbus_pkg;

    localparam int BUS_W = 16;

    localparam logic [BUS_W-1:0] ID_BADDR   = 16'h2468;
    localparam logic [BUS_W-1:0] PUSH_BADDR = 16'h4000;
    localparam logic [BUS_W-1:0] POP_BADDR  = 16'h4002;
    localparam logic [BUS_W-1:0] ID_WORD    = 16'h55AA;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_READ  = 3'd2,
        ST_WRITE = 3'd3,
        ST_END   = 3'd4
    } bus_state_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_ID   = 2'd1,
        SEL_STAT = 2'd2,
        SEL_POP  = 2'd3
    } rd_sel_t;

endpackage

// File: rtl/adbus_sync.sv
module adbus_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= RST_VAL;
                else        chain[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= RST_VAL;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/adbus_fifo.sv
module adbus_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW:0]   wp, rp;

    assign count = wp - rp;
    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign head  = mem[rp[AW-1:0]];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push && !full)  wp <= wp + 1'b1;
            if (pop  && !empty) rp <= rp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full) mem[wp[AW-1:0]] <= wdata;
    end

endmodule

// File: rtl/adbus_ctrl.sv
module adbus_ctrl
    import adbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_s,
    input  logic             av_s,
    input  logic             oe_s,
    input  logic             we_s,
    input  logic [BUS_W-1:0] ad_s,
    output logic             push,
    output logic             pop,
    output logic [BUS_W-1:0] wdata,
    output rd_sel_t          rsel
);

    bus_state_t       state, nstate;
    logic [BUS_W-1:1] waddr_q;
    logic             hit_id, hit_push, hit_pop;

    assign hit_id   = (waddr_q == ID_BADDR[BUS_W-1:1]);
    assign hit_push = (waddr_q == PUSH_BADDR[BUS_W-1:1]);
    assign hit_pop  = (waddr_q == POP_BADDR[BUS_W-1:1]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:  if (!cs_s && !av_s) nstate = ST_ADDR;
            ST_ADDR: begin
                if (cs_s)                 nstate = ST_IDLE;
                else if (av_s && !oe_s)   nstate = ST_READ;
                else if (av_s && !we_s)   nstate = ST_WRITE;
            end
            ST_READ: begin
                if (cs_s)                 nstate = ST_IDLE;
                else if (oe_s)            nstate = ST_END;
            end
            ST_WRITE: begin
                if (cs_s)                 nstate = ST_IDLE;
                else if (we_s)            nstate = ST_END;
            end
            ST_END: begin
                if (cs_s)                 nstate = ST_IDLE;
                else if (!av_s)           nstate = ST_ADDR;
            end
            default:                      nstate = ST_IDLE;
        endcase
    end

    always_comb begin
        push = (state == ST_WRITE) && !cs_s && we_s && hit_push;
        pop  = (state == ST_READ)  && !cs_s && oe_s && hit_pop;
        if (hit_id)        rsel = SEL_ID;
        else if (hit_push) rsel = SEL_STAT;
        else if (hit_pop)  rsel = SEL_POP;
        else               rsel = SEL_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            waddr_q <= '0;
            wdata   <= '0;
        end else begin
            if (!cs_s && !av_s)                waddr_q <= ad_s[BUS_W-1:1];
            if ((state == ST_WRITE) && !we_s)  wdata   <= ad_s;
        end
    end

endmodule

// File: rtl/adbus_fifo_slave.sv
module adbus_fifo_slave
    import adbus_pkg::*;
#(
    parameter int FIFO_DEPTH  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_cs_n,
    input  logic             bus_av_n,
    input  logic             bus_oe_n,
    input  logic             bus_we_n,
    inout  wire  [BUS_W-1:0] bus_ad
);

    localparam int CW = $clog2(FIFO_DEPTH) + 1;

    logic [3:0]       strobe_s;
    logic [BUS_W-1:0] ad_s;
    logic             push_w, pop_w;
    logic [BUS_W-1:0] wdata_w, head_w, rd_word;
    logic [CW-1:0]    fifo_count;
    logic             fifo_full, fifo_empty;
    rd_sel_t          rsel_w;

    adbus_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1111)) u_sync_strobe (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({bus_cs_n, bus_av_n, bus_oe_n, bus_we_n}),
        .q     (strobe_s)
    );

    adbus_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_ad (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_ad),
        .q     (ad_s)
    );

    adbus_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_s  (strobe_s[3]),
        .av_s  (strobe_s[2]),
        .oe_s  (strobe_s[1]),
        .we_s  (strobe_s[0]),
        .ad_s  (ad_s),
        .push  (push_w),
        .pop   (pop_w),
        .wdata (wdata_w),
        .rsel  (rsel_w)
    );

    adbus_fifo #(.DW(BUS_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push_w),
        .pop   (pop_w),
        .wdata (wdata_w),
        .head  (head_w),
        .count (fifo_count),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    always_comb begin
        unique case (rsel_w)
            SEL_ID:   rd_word = ID_WORD;
            SEL_STAT: rd_word = {{(BUS_W-CW){1'b0}}, fifo_count};
            SEL_POP:  rd_word = fifo_empty ? '0 : head_w;
            default:  rd_word = '0;
        endcase
    end

    assign bus_ad = (!bus_cs_n && !bus_oe_n) ? rd_word : {BUS_W{1'bz}};

endmodule

// File: rtl/adbus_fifo_slave_chk.sv
module adbus_fifo_slave_chk #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push,
    input logic          pop,
    input logic [CW-1:0] count,
    input logic          full,
    input logic          empty
);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R8

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push) |=> (count == CW'(DEPTH))); // R8

    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop) |=> (count == '0)); // R7

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop)); // R10

    AST_POP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> !pop); // R10

    AST_PUSH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !push); // R4

endmodule

bind adbus_fifo_slave adbus_fifo_slave_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push_w),
    .pop   (pop_w),
    .count (fifo_count),
    .full  (fifo_full),
    .empty (fifo_empty)
);

// File: tb/adbus_fifo_slave_test.sv
module adbus_fifo_slave_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, av_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [15:0] host_ad = '0;
    logic        host_drive = 1'b0;
    wire  [15:0] ad;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    assign ad = host_drive ? host_ad : 16'hzzzz;

    always #10 clk = ~clk;

    adbus_fifo_slave uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_cs_n (cs_n),
        .bus_av_n (av_n),
        .bus_oe_n (oe_n),
        .bus_we_n (we_n),
        .bus_ad   (ad)
    );

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [15:0] data;
        int          req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 16'h4000, 16'h1111, 4},  // R4 push
        '{1'b1, 16'h4000, 16'h1112, 4},  // R4 push
        '{1'b1, 16'h4000, 16'h1113, 4},  // R4 push
        '{1'b0, 16'h4000, 16'h0003, 6},  // R6 occupancy
        '{1'b0, 16'h2468, 16'h55AA, 3},  // R3 id word
        '{1'b0, 16'h4002, 16'h1111, 5},  // R5 oldest first
        '{1'b0, 16'h4002, 16'h1112, 5},  // R5
        '{1'b0, 16'h4000, 16'h0001, 6},  // R6
        '{1'b1, 16'h1000, 16'hBEEF, 4},  // R4 undecoded write
        '{1'b0, 16'h4000, 16'h0001, 4},  // R4 count unchanged
        '{1'b0, 16'h4002, 16'h1113, 5},  // R5
        '{1'b0, 16'h4002, 16'h0000, 7},  // R7 empty pop
        '{1'b0, 16'h4000, 16'h0000, 7},  // R7 still empty
        '{1'b1, 16'h4001, 16'h7777, 2},  // R2 bit 0 ignored
        '{1'b0, 16'h4002, 16'h7777, 2},  // R2
        '{1'b0, 16'h2469, 16'h55AA, 2},  // R2
        '{1'b0, 16'h0100, 16'h0000, 3}   // R3 undecoded read
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic addr_phase(input logic [15:0] a);
        @(negedge clk);
        cs_n = 1'b0; host_ad = a; host_drive = 1'b1; av_n = 1'b0;
        repeat (3) @(negedge clk);
        av_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
        addr_phase(a);
        host_ad = d; we_n = 1'b0;
        repeat (3) @(negedge clk);
        we_n = 1'b1;
        repeat (3) @(negedge clk);
        host_drive = 1'b0; cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [15:0] d0, output logic [15:0] d1);
        addr_phase(a);
        host_drive = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        d0 = ad;
        repeat (2) @(negedge clk);
        d1 = ad;
        oe_n = 1'b1;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] r0, r1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: reset state, FIFO empty
        bus_read(16'h4000, r0, r1);
        check("R1 occupancy after reset", r0, 16'h0000);

        // R9: lines released while chip select is high, even with OE low
        host_ad = 16'h3C3C; host_drive = 1'b1; oe_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 released with cs high", ad, 16'h3C3C);
        oe_n = 1'b1;
        // R9: released while chip select low but OE high
        cs_n = 1'b0; host_ad = 16'hC3C3;
        repeat (2) @(negedge clk);
        check("R9 released with oe high", ad, 16'hC3C3);
        cs_n = 1'b1; host_drive = 1'b0;
        repeat (4) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) begin
                bus_write(VEC[i].addr, VEC[i].data);
            end else begin
                bus_read(VEC[i].addr, r0, r1);
                check($sformatf("R%0d row %0d", VEC[i].req, i), r0, VEC[i].data);
            end
        end

        // R8: fill past capacity, the extra word is dropped
        for (int i = 0; i < 17; i++) bus_write(16'h4000, 16'hA000 + 16'(i));
        bus_read(16'h4000, r0, r1);
        check("R8 occupancy when full", r0, 16'h0010);
        // R10: stable during OE, one entry per read
        for (int i = 0; i < 16; i++) begin
            bus_read(16'h4002, r0, r1);
            check($sformatf("R8 drain %0d", i), r0, 16'hA000 + 16'(i));
            check($sformatf("R10 stable word %0d", i), r1, r0);
        end
        bus_read(16'h4002, r0, r1);
        check("R8 dropped word absent", r0, 16'h0000);

        // R11: chip select released before write strobe ends
        addr_phase(16'h4000);
        host_ad = 16'h5151; we_n = 1'b0;
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        we_n = 1'b1; host_drive = 1'b0;
        repeat (4) @(negedge clk);
        bus_read(16'h4000, r0, r1);
        check("R11 abandoned write", r0, 16'h0000);

        // R10: back-to-back reads under one chip select, one pop each
        bus_write(16'h4000, 16'h0A0A);
        bus_write(16'h4000, 16'h0B0B);
        addr_phase(16'h4002);
        host_drive = 1'b0; oe_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 first of pair", ad, 16'h0A0A);
        oe_n = 1'b1;
        repeat (4) @(negedge clk);
        host_ad = 16'h4002; host_drive = 1'b1; av_n = 1'b0;
        repeat (3) @(negedge clk);
        av_n = 1'b1;
        @(negedge clk);
        host_drive = 1'b0; oe_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 second of pair", ad, 16'h0B0B);
        oe_n = 1'b1;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        bus_read(16'h4000, r0, r1);
        check("R10 emptied by two reads", r0, 16'h0000);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule